// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Interface

This block connects a small on-chip byte array to a two-wire serial bus as a slave only. A master starts every transfer with a start condition and then sends a select byte. The block checks the device type code in that byte and its chip-enable bits against three strap pins. It acknowledges only a select byte that matches. It then takes an address and data bytes for a write, or sends stored bytes for a read. SDA is driven open-drain: the single output pulls the line low and otherwise leaves it released. Both bus lines are synchronised into the system clock domain before any event is decoded.

Written bytes go into a small page buffer. A stop condition that ends a write holding at least one data byte starts a programming period of a fixed number of system clocks. The buffered bytes are committed to the array when that period ends. During the period the bus is ignored entirely. A stop that ends a read, or a write that only set the address, returns the block to standby at once.

The controller has these states. IDLE waits for a start. SELECT shifts in the select byte; on a match it moves to SEL_ACK, and on a mismatch it returns to IDLE. SEL_ACK moves to RDATA for a read or to AHI for a write. AHI leads to AHI_ACK, then ALO, then ALO_ACK, then WDATA. WDATA and WACK alternate for each data byte. RDATA moves to RACK. RACK returns to RDATA when the master acknowledges and moves to WAIT_STOP when it does not. PROG counts the programming period and then returns to IDLE. From every state except PROG, a start moves to SELECT. A stop moves to PROG when data bytes are pending and to IDLE otherwise.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. Without a start, clocked bits are never acknowledged.
- R2: The select byte is sent MSB first. Bits 7:4 must equal 4'b1010 and bits 3:1 must equal `ce_pins`. Bit 0 selects the direction (1 = read, 0 = write). On a match the block pulls SDA low for the 9th clock.
- R3: When the select byte does not match, SDA stays released for the acknowledge and for every later byte until the next start.
- R4: A write takes two address bytes, high byte first, and each is acknowledged. Together they set the 13-bit pointer from bits 12:8 of the high byte and all bits of the low byte; the upper 3 bits of the high byte are dropped.
- R5: Every write data byte is acknowledged and the pointer then advances by one. Only the first PAGE_MAX bytes of a transfer are latched; later bytes are acknowledged and dropped.
- R6: A stop that ends a write with at least one data byte raises `busy` for exactly PROG_CYCLES clocks. The latched bytes are then stored at consecutive addresses from the first data address, and `busy` clears.
- R7: While `busy` is high, start conditions and clocks are ignored and SDA stays released.
- R8: A stop after a write that carried only the address does not raise `busy`, and the pointer keeps the new address.
- R9: A read sends the byte at the pointer MSB first and advances the pointer after each byte. It continues while the master acknowledges. After a missing acknowledge it releases SDA and waits for a stop or start.
- R10: A stop after a read returns to standby without `busy`, and the next matching select is acknowledged.
- R11: The array index is the pointer modulo MEM_DEPTH (a power of two), so accesses wrap around the array.
- R12: The block changes its SDA drive only while SCL is low.
- R13: After reset SDA is released, `busy` is low and every array byte reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired bus) |
| ce_pins | input | 3 | Chip-enable strap pins matched against select bits 3:1 |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| busy | output | 1 | High during the internal programming period |

## Verification
The bench targets select bytes that differ only in the type code or only in one chip-enable bit. A design that matched too loosely would acknowledge them and take in stray writes. It writes more bytes than the page limit and reads them back. A design without the limit would store the extra bytes, and one that stopped advancing the pointer would shift later reads. It places writes and reads across the top of the array and holds a start during the programming period. A design that did not wrap would corrupt the wrong bytes, and one that listened while busy would acknowledge. It also ends writes that carry only an address and checks the programming length exactly. A design that started programming on such a write would raise `busy`, and a wrong period shows up as a length mismatch.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SELECT,
        ST_SEL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT_STOP,
        ST_PROG
    } bus_state_t;

endpackage

// File: rtl/twi_line_monitor.sv
module twi_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_s,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_prev, sda_prev;
    logic scl_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_raw;
                    sda_pipe <= sda_raw;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_raw};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_raw};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign ev_rise  = scl_s & ~scl_prev;
    assign ev_fall  = ~scl_s & scl_prev;
    assign ev_start = scl_s & scl_prev & sda_prev & ~sda_s;
    assign ev_stop  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/twi_prog_timer.sv
module twi_prog_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic done
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] remain;
    logic          running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain  <= '0;
            running <= 1'b0;
        end else if (go) begin
            remain  <= TW'(CYCLES - 1);
            running <= 1'b1;
        end else if (running) begin
            if (remain == '0) running <= 1'b0;
            else              remain  <= remain - TW'(1);
        end
    end

    assign done = running && (remain == '0);

endmodule

// File: rtl/twi_byte_store.sv
module twi_byte_store #(
    parameter int MEM_DEPTH = 256,
    parameter int PAGE_MAX  = 4,
    localparam int IDX_W    = $clog2(MEM_DEPTH),
    localparam int PCNT_W   = $clog2(PAGE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_en,
    input  logic [PCNT_W-1:0] lat_slot,
    input  logic [7:0]        lat_byte,
    input  logic              commit,
    input  logic [IDX_W-1:0]  commit_base,
    input  logic [PCNT_W-1:0] commit_cnt,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_byte
);
    logic [7:0] cells [MEM_DEPTH];
    logic [7:0] page  [PAGE_MAX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_MAX; i++) page[i] <= 8'h00;
        end else if (lat_en) begin
            page[lat_slot] <= lat_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) cells[i] <= 8'h00;
        end else if (commit) begin
            for (int i = 0; i < PAGE_MAX; i++) begin
                if (PCNT_W'(i) < commit_cnt)
                    cells[commit_base + IDX_W'(i)] <= page[i];
            end
        end
    end

    assign rd_byte = cells[rd_idx];

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int MEM_DEPTH   = 256,
    parameter int PAGE_MAX    = 4,
    parameter int PROG_CYCLES = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] ce_pins,
    output logic       sda_drive_low,
    output logic       busy
);
    localparam int IDX_W  = $clog2(MEM_DEPTH);
    localparam int PCNT_W = $clog2(PAGE_MAX + 1);

    bus_state_t          state;
    logic [3:0]          bit_cnt;
    logic [7:0]          shreg;
    logic [7:0]          addr_hi;
    logic [ADDR_W-1:0]   ptr;
    logic [PCNT_W-1:0]   wr_cnt;
    logic [IDX_W-1:0]    wr_base;
    logic                rw_bit;
    logic                m_ack;
    logic                lat_en;
    logic [PCNT_W-1:0]   lat_slot;
    logic [7:0]          lat_byte;

    logic sda_s, ev_start, ev_stop, ev_rise, ev_fall;
    logic prog_go, prog_done, commit;
    logic [7:0] rd_byte;
    logic sel_match;

    twi_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .sda_raw  (sda_in),
        .sda_s    (sda_s),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall)
    );

    twi_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (prog_go),
        .done  (prog_done)
    );

    twi_byte_store #(.MEM_DEPTH(MEM_DEPTH), .PAGE_MAX(PAGE_MAX)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .lat_en      (lat_en),
        .lat_slot    (lat_slot),
        .lat_byte    (lat_byte),
        .commit      (commit),
        .commit_base (wr_base),
        .commit_cnt  (wr_cnt),
        .rd_idx      (ptr[IDX_W-1:0]),
        .rd_byte     (rd_byte)
    );

    assign sel_match = (shreg[7:4] == DEV_TYPE_CODE) && (shreg[3:1] == ce_pins);
    assign prog_go   = (state != ST_PROG) && !ev_start && ev_stop && (wr_cnt != '0);
    assign commit    = (state == ST_PROG) && prog_done;

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            addr_hi  <= '0;
            ptr      <= '0;
            wr_cnt   <= '0;
            wr_base  <= '0;
            rw_bit   <= 1'b0;
            m_ack    <= 1'b0;
            lat_en   <= 1'b0;
            lat_slot <= '0;
            lat_byte <= '0;
        end else begin
            lat_en <= 1'b0;
            if (state == ST_PROG) begin
                if (prog_done) begin
                    state  <= ST_IDLE;
                    wr_cnt <= '0;
                end
            end else if (ev_start) begin
                state   <= ST_SELECT;
                bit_cnt <= '0;
                wr_cnt  <= '0;
            end else if (ev_stop) begin
                state <= (wr_cnt != '0) ? ST_PROG : ST_IDLE;
            end else begin
                unique case (state)
                    ST_SELECT, ST_AHI, ST_ALO, ST_WDATA: begin
                        if (ev_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == ST_SELECT) begin
                                if (sel_match) begin
                                    rw_bit <= shreg[0];
                                    state  <= ST_SEL_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_AHI) begin
                                addr_hi <= shreg;
                                state   <= ST_AHI_ACK;
                            end else if (state == ST_ALO) begin
                                ptr   <= ADDR_W'({addr_hi, shreg});
                                state <= ST_ALO_ACK;
                            end else begin
                                if (wr_cnt < PCNT_W'(PAGE_MAX)) begin
                                    lat_en   <= 1'b1;
                                    lat_slot <= wr_cnt;
                                    lat_byte <= shreg;
                                    wr_cnt   <= wr_cnt + PCNT_W'(1);
                                end
                                if (wr_cnt == '0) wr_base <= ptr[IDX_W-1:0];
                                ptr   <= ptr + ADDR_W'(1);
                                state <= ST_WACK;
                            end
                        end
                    end
                    ST_SEL_ACK: begin
                        if (ev_fall) begin
                            bit_cnt <= '0;
                            if (rw_bit) begin
                                shreg <= rd_byte;
                                ptr   <= ptr + ADDR_W'(1);
                                state <= ST_RDATA;
                            end else begin
                                state <= ST_AHI;
                            end
                        end
                    end
                    ST_AHI_ACK: if (ev_fall) state <= ST_ALO;
                    ST_ALO_ACK: if (ev_fall) state <= ST_WDATA;
                    ST_WACK:    if (ev_fall) state <= ST_WDATA;
                    ST_RDATA: begin
                        if (ev_fall) begin
                            if (bit_cnt == 4'd7) begin
                                bit_cnt <= '0;
                                state   <= ST_RACK;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b1};
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev_rise) begin
                            m_ack <= ~sda_s;
                        end else if (ev_fall) begin
                            if (m_ack) begin
                                shreg <= rd_byte;
                                ptr   <= ptr + ADDR_W'(1);
                                state <= ST_RDATA;
                            end else begin
                                state <= ST_WAIT_STOP;
                            end
                        end
                    end
                    ST_IDLE, ST_WAIT_STOP, ST_PROG: ;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        sda_drive_low = 1'b0;
        unique case (state)
            ST_SEL_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WACK: sda_drive_low = 1'b1;
            ST_RDATA: sda_drive_low = ~shreg[7];
            default:  sda_drive_low = 1'b0;
        endcase
        busy = (state == ST_PROG);
    end

endmodule

// File: rtl/twi_eeprom_slave_checker.sv
module twi_eeprom_slave_checker #(
    parameter int PROG_CYCLES = 400
) (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_drive_low,
    input logic busy,
    input logic ev_start,
    input logic ev_stop,
    input logic ev_rise,
    input logic ev_fall
);
    int unsigned busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R7: no drive on SDA during programming
    p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_drive_low);

    // R6: programming starts only from a stop condition
    p_busy_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ev_stop));

    // R6: programming period has the configured length
    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == PROG_CYCLES);

    // R12: SDA drive holds while SCL stays high
    p_sda_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && $past(scl_in)) |-> $stable(sda_drive_low));

    // R1: line events never coincide
    p_events_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_stop, ev_rise, ev_fall}));

endmodule

bind twi_eeprom_slave twi_eeprom_slave_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_in),
    .sda_drive_low (sda_drive_low),
    .busy          (busy),
    .ev_start      (ev_start),
    .ev_stop       (ev_stop),
    .ev_rise       (ev_rise),
    .ev_fall       (ev_fall)
);

// File: tb/twi_eeprom_slave_test.sv
module twi_eeprom_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int HP    = 8;
    localparam int AW    = 13;
    localparam int DEPTH = 256;
    localparam int PMAX  = 4;
    localparam int PCYC  = 400;
    localparam logic [2:0] CE = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_low, busy;
    logic sda_bus;

    assign sda_bus = m_sda & ~sda_low;
    always #(CLK_PERIOD/2) clk = ~clk;

    twi_eeprom_slave #(
        .ADDR_W(AW), .MEM_DEPTH(DEPTH), .PAGE_MAX(PMAX), .PROG_CYCLES(PCYC), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .ce_pins(CE), .sda_drive_low(sda_low), .busy(busy)
    );

    int checks = 0;
    int fails = 0;
    bit ended = 0;
    logic [7:0]    bmem [DEPTH];
    logic [7:0]    wbuf [8];
    logic [AW-1:0] mptr;
    int busy_run = 0;
    int last_busy = 0;

    always @(negedge clk) begin
        if (busy) busy_run++;
        else begin
            if (busy_run != 0) last_busy = busy_run;
            busy_run = 0;
        end
    end

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(logic [AW-1:0] a);
        return bmem[int'(a) % DEPTH];
    endfunction

    function automatic logic [7:0] sel(bit rw, logic [2:0] ce);
        return {4'b1010, ce, rw};
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; wt(HP);
        m_scl = 1'b1; wt(HP);
        m_sda = 1'b0; wt(HP);
        m_scl = 1'b0; wt(HP/2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(HP);
        m_scl = 1'b1; wt(HP);
        m_sda = 1'b1; wt(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(HP);
            m_scl = 1'b1; wt(HP);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; wt(HP);
        m_scl = 1'b1; wt(HP/2);
        acked = (sda_bus == 1'b0);
        wt(HP/2);
        m_scl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wt(HP);
            m_scl = 1'b1; wt(HP/2);
            b = {b[6:0], sda_bus};
            wt(HP/2);
            m_scl = 1'b0;
        end
        m_sda = give_ack ? 1'b0 : 1'b1; wt(HP);
        m_scl = 1'b1; wt(HP);
        m_scl = 1'b0; wt(HP/2);
        m_sda = 1'b1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < PCYC + 100 && busy; i++) wt(1);
    endtask

    // Full write: select, two address bytes, n data bytes from wbuf, stop
    task automatic do_write(logic [AW-1:0] addr, int n);
        bit a;
        bus_start();
        send_byte(sel(1'b0, CE), a);  chk(a, "R2 write select ack", a, 1);
        send_byte({3'b000, addr[12:8]}, a); chk(a, "R4 high address ack", a, 1);
        send_byte(addr[7:0], a);      chk(a, "R4 low address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);    chk(a, "R5 data byte ack", a, 1);
        end
        bus_stop();
        for (int i = 0; i < n && i < PMAX; i++) bmem[(int'(addr) + i) % DEPTH] = wbuf[i];
        mptr = addr + AW'(n);
        if (n > 0) begin
            chk(busy == 1'b1, "R6 busy after write stop", busy, 1);
            wait_idle();
            wt(2);
            chk(busy == 1'b0, "R6 busy clears", busy, 0);
            chk(last_busy == PCYC, "R6 busy length", last_busy, PCYC);
        end else begin
            wt(4);
            chk(busy == 1'b0, "R8 address-only write no busy", busy, 0);
        end
    endtask

    // Random read: set address, repeated start, read n bytes
    task automatic do_read(logic [AW-1:0] addr, int n, string tag);
        bit a;
        logic [7:0] got;
        bus_start();
        send_byte(sel(1'b0, CE), a);  chk(a, "R2 select ack", a, 1);
        send_byte({3'b000, addr[12:8]}, a); chk(a, "R4 high address ack", a, 1);
        send_byte(addr[7:0], a);      chk(a, "R4 low address ack", a, 1);
        bus_start();
        send_byte(sel(1'b1, CE), a);  chk(a, "R9 read select ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, got);
            chk(got == exp_byte(addr + AW'(i)), tag, got, exp_byte(addr + AW'(i)));
        end
        wt(2);
        chk(sda_low == 1'b0, "R9 released after master nack", sda_low, 0);
        mptr = addr + AW'(n);
        bus_stop();
        wt(4);
        chk(busy == 1'b0, "R10 no busy after read stop", busy, 0);
    endtask

    task automatic cur_read();
        bit a;
        logic [7:0] got;
        bus_start();
        send_byte(sel(1'b1, CE), a);  chk(a, "R10 select ack after read", a, 1);
        recv_byte(1'b0, got);
        chk(got == exp_byte(mptr), "R9 pointer advance current read", got, exp_byte(mptr));
        mptr = mptr + AW'(1);
        bus_stop();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
        finish_run();
    end

    initial begin
        bit a;
        logic [7:0] got;
        void'($urandom(32'h0000_5eed));
        for (int i = 0; i < DEPTH; i++) bmem[i] = 8'h00;
        mptr = '0;
        wt(5);
        rst_n = 1'b1;
        wt(3);

        // R13: reset state
        chk(sda_low == 1'b0, "R13 sda released", sda_low, 0);
        chk(busy == 1'b0, "R13 busy low", busy, 0);
        do_read(13'h0033, 2, "R13 array cleared");

        // R1: byte without a start is not acknowledged
        m_scl = 1'b0; wt(HP);
        send_byte(sel(1'b0, CE), a);
        chk(!a, "R1 no ack without start", a, 0);
        bus_stop();

        // R3: chip-enable mismatch, then type mismatch
        bus_start();
        send_byte(sel(1'b0, 3'b100), a); chk(!a, "R3 ce mismatch nack", a, 0);
        send_byte(8'h00, a);             chk(!a, "R3 silent after mismatch", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, CE, 1'b0}, a); chk(!a, "R3 type mismatch nack", a, 0);
        bus_stop();
        wt(4);
        chk(busy == 1'b0, "R3 no busy after mismatch", busy, 0);

        // R4/R5/R6/R7: write with start during programming
        wbuf[0] = 8'h3C; wbuf[1] = 8'h00; wbuf[2] = 8'hFF;
        bus_start();
        send_byte(sel(1'b0, CE), a); chk(a, "R2 select ack", a, 1);
        send_byte(8'hE0, a);         chk(a, "R4 high address ack", a, 1);
        send_byte(8'h10, a);         chk(a, "R4 low address ack", a, 1);
        for (int i = 0; i < 3; i++) begin
            send_byte(wbuf[i], a);   chk(a, "R5 data ack", a, 1);
        end
        bus_stop();
        chk(busy == 1'b1, "R6 busy after stop", busy, 1);
        bus_start();
        send_byte(sel(1'b0, CE), a); chk(!a, "R7 ignored while busy", a, 0);
        chk(busy == 1'b1, "R7 still busy", busy, 1);
        bus_stop();
        for (int i = 0; i < 3; i++) bmem[16 + i] = wbuf[i];
        wait_idle(); wt(2);
        chk(last_busy == PCYC, "R6 busy length", last_busy, PCYC);
        do_read(13'h0010, 3, "R4 readback ignores high bits");
        cur_read();

        // R8: address-only write then current read
        do_write(13'h0011, 0);
        cur_read();

        // R5: page overflow
        for (int i = 0; i < 6; i++) wbuf[i] = 8'hA0 + 8'(i);
        do_write(13'h0040, 6);
        do_read(13'h0040, 6, "R5 page limit readback");
        cur_read();

        // R11: wrap across the array end
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
        do_write(13'h1FFF, 2);
        do_read(13'h00FF, 2, "R11 wrap readback");
        do_read(13'h0AFF, 2, "R11 pointer modulo depth");

        // Random mix
        for (int k = 0; k < 8; k++) begin
            logic [AW-1:0] ad;
            int n;
            ad = AW'($urandom % 8192);
            n  = 1 + int'($urandom % (PMAX + 2));
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(ad, n);
            do_read(ad, n, "R9 random readback");
            cur_read();
        end

        finish_run();
    end

endmodule